// File: doc/BRIEF.md
# Character Cell Pixel Colour Renderer

This block sits between a text-mode raster scanner and the colour output of a display path. Each clock it takes four inputs: a character code, a foreground palette index, a background palette index, and the row and column of the current pixel inside an 8×8 character cell. From these it produces one 6-bit pixel colour. The glyph shapes are held in three synchronous-read glyph banks of 64 codes each. The two colour lookups come from two separate 16-entry palette ROMs, one for the foreground and one for the background.

The block is fully pipelined. A new pixel can be presented on every clock, and its colour appears two clock edges later. The column index and the control flags travel alongside the ROM reads so that each selected glyph bit meets its own row byte. A blanking input forces the output to black for the pixel it accompanies.

Top module: `glyph_pixel_render`

## Requirements
- R1: Glyphs are split into three banks chosen by code[7:6] (0: codes 0–63, 1: 64–127, 2: 128–191). Inside a bank, the row byte sits at local address {code[5:0], row[2:0]}, so code 0x41 uses local addresses 0x08–0x0F of bank 1.
- R2: The built-in glyph content for code c and row r is the byte c XOR {r[2:0], r[1:0], r[2:0]}. Row 0 is the top row of the cell.
- R3: Inside a row byte, column 0 (leftmost) selects bit 7 and column k selects bit 7−k.
- R4: A set glyph bit outputs the foreground palette entry for fg_idx. A clear bit outputs the background palette entry for bg_idx.
- R5: Palette entries are 6 bits wide, with blue in [5:4], green in [3:2] and red in [1:0]. Entries 0..15 are 0x00, 0x3F, 0x03, 0x0C, 0x30, 0x0F, 0x33, 0x3C, 0x15, 0x2A, 0x01, 0x04, 0x10, 0x05, 0x14, 0x11. Entry 0 is black, 1 is white and 2 is pure red.
- R6: The foreground and background lookups are independent reads that happen in the same cycle. Changing one index never alters the other lookup.
- R7: Codes 192–255 render as an empty glyph, so every pixel of such a cell takes the background colour.
- R8: When blank_in is 1 for a pixel, the output for that pixel is 0x00, whatever the other inputs are.
- R9: The output for inputs sampled at clock edge N is visible after edge N+1, and a new pixel is accepted on every edge.
- R10: While rst_n is 0 at a clock edge, pix_color becomes 0x00 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_code | input | 8 | Character code of the current cell |
| fg_idx | input | 4 | Foreground palette index |
| bg_idx | input | 4 | Background palette index |
| cell_row | input | 3 | Pixel row inside the cell (0 = top) |
| cell_col | input | 3 | Pixel column inside the cell (0 = left) |
| blank_in | input | 1 | Forces this pixel to black |
| pix_color | output | 6 | Pixel colour, BBGGRR |

## Verification
Blanking can land on the same pixel as any glyph decision, including a set bit in a valid bank and a code at or above 192. These cases are provoked during a full sweep of every code, row and column: blank_in is raised on a sparse arithmetic pattern of pixels, so it lands at scattered cell positions, banks and bit values. Every such pixel is judged as pure black. The pixel on each side of it must still carry its own glyph or background colour, which shows that blanking neither spills into nor lags behind its neighbours in the pipeline. The foreground and background reads also fall in the same cycle. The bench judges this by sweeping one palette index while it holds the other on a different entry.

// File: rtl/glyph_render_pkg.sv
// Package: shared sizes and the computed ROM contents for the renderer.
// Assumes 8x8 cells and 6-bit BBGGRR colour throughout.
package glyph_render_pkg;

    localparam int CELL_DIM    = 8;
    localparam int ROW_W       = $clog2(CELL_DIM);
    localparam int CODE_W      = 8;
    localparam int COLOR_W     = 6;
    localparam int PAL_DEPTH   = 16;
    localparam int PAL_IDX_W   = $clog2(PAL_DEPTH);

    typedef logic [CELL_DIM-1:0] row_byte_t;
    typedef logic [COLOR_W-1:0]  color_t;

    // Built-in glyph row content: code XOR a row-dependent stripe.
    function automatic row_byte_t glyph_row(input logic [CODE_W-1:0] code,
                                            input logic [ROW_W-1:0]  row);
        return code ^ {row, row[1:0], row};
    endfunction

    // Palette contents, BBGGRR.
    function automatic color_t palette_entry(input logic [PAL_IDX_W-1:0] idx);
        color_t c;
        case (idx)
            4'd0:  c = 6'h00;
            4'd1:  c = 6'h3F;
            4'd2:  c = 6'h03;
            4'd3:  c = 6'h0C;
            4'd4:  c = 6'h30;
            4'd5:  c = 6'h0F;
            4'd6:  c = 6'h33;
            4'd7:  c = 6'h3C;
            4'd8:  c = 6'h15;
            4'd9:  c = 6'h2A;
            4'd10: c = 6'h01;
            4'd11: c = 6'h04;
            4'd12: c = 6'h10;
            4'd13: c = 6'h05;
            4'd14: c = 6'h14;
            default: c = 6'h11;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/glyph_bank.sv
// Module: one bank of glyph rows, read synchronously.
// Assumes the local address is {code[5:0], row}; the bank number supplies
// the upper code bits when the content is computed.
module glyph_bank
    import glyph_render_pkg::*;
#(
    parameter int BANK_NUM   = 0,
    parameter int BANK_CODES = 64,
    localparam int LCODE_W   = $clog2(BANK_CODES),
    localparam int ADDR_W    = LCODE_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output row_byte_t         rdata
);

    logic [CODE_W-1:0] full_code;

    // Rebuild the full character code from bank number and local code.
    always_comb begin
        full_code = CODE_W'(BANK_NUM * BANK_CODES) | CODE_W'(addr[ADDR_W-1:ROW_W]);
    end

    // Registered ROM read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= glyph_row(full_code, addr[ROW_W-1:0]);
    end

endmodule

// File: rtl/palette_rom.sv
// Module: 16-entry colour palette with a registered read port.
// Assumes one instance per colour role so both lookups run in parallel.
module palette_rom
    import glyph_render_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PAL_IDX_W-1:0] idx,
    output color_t               color
);

    // Registered palette read.
    always_ff @(posedge clk) begin
        if (!rst_n) color <= '0;
        else        color <= palette_entry(idx);
    end

endmodule

// File: rtl/pixel_select.sv
// Module: second pipeline stage; picks the row byte of the addressed bank,
// selects the column bit (MSB = leftmost) and chooses the colour.
// Assumes every input is already one stage old and aligned with the ROM data.
module pixel_select
    import glyph_render_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int BSEL_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  row_byte_t [NUM_BANKS-1:0]      bank_bytes,
    input  logic [BSEL_W-1:0]              bank_sel,
    input  logic                           code_ok,
    input  logic [ROW_W-1:0]               col,
    input  logic                           blank,
    input  color_t                         fg_color,
    input  color_t                         bg_color,
    output color_t                         pix
);

    row_byte_t row_byte;
    logic      bit_on;

    // Mux the addressed bank; out-of-range codes give an empty row.
    always_comb begin
        row_byte = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (code_ok && (bank_sel == BSEL_W'(b))) row_byte = bank_bytes[b];
        end
        bit_on = row_byte[(CELL_DIM-1) - int'(col)];
    end

    // Output register with blanking override.
    always_ff @(posedge clk) begin
        if (!rst_n)      pix <= '0;
        else if (blank)  pix <= '0;
        else if (bit_on) pix <= fg_color;
        else             pix <= bg_color;
    end

endmodule

// File: rtl/glyph_pixel_render.sv
// Module: top of the character-cell renderer. Stage 1 reads the glyph
// banks and both palettes and delays the side information; stage 2
// picks the pixel. Latency is two clocks, with one pixel per clock.
// Assumes cell row and column are valid for an 8x8 cell.
module glyph_pixel_render
    import glyph_render_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    parameter int BANK_CODES = 64,
    localparam int LCODE_W   = $clog2(BANK_CODES),
    localparam int ADDR_W    = LCODE_W + ROW_W,
    localparam int CODE_LIM  = NUM_BANKS * BANK_CODES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CODE_W-1:0]    char_code,
    input  logic [PAL_IDX_W-1:0] fg_idx,
    input  logic [PAL_IDX_W-1:0] bg_idx,
    input  logic [ROW_W-1:0]     cell_row,
    input  logic [ROW_W-1:0]     cell_col,
    input  logic                 blank_in,
    output logic [COLOR_W-1:0]   pix_color
);

    row_byte_t [NUM_BANKS-1:0] bank_bytes;
    color_t                    fg_q, bg_q;
    logic [1:0]                bsel_q;
    logic                      ok_q, blank_q;
    logic [ROW_W-1:0]          col_q;
    logic [ADDR_W-1:0]         local_addr;

    // Local bank address: low code bits then row.
    always_comb begin
        local_addr = {char_code[LCODE_W-1:0], cell_row};
    end

    // One glyph bank per 64-code range.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        glyph_bank #(.BANK_NUM(b), .BANK_CODES(BANK_CODES)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .addr  (local_addr),
            .rdata (bank_bytes[b])
        );
    end

    palette_rom u_fg_pal (.clk(clk), .rst_n(rst_n), .idx(fg_idx), .color(fg_q));
    palette_rom u_bg_pal (.clk(clk), .rst_n(rst_n), .idx(bg_idx), .color(bg_q));

    // Delay bank select, code range, column and blank to match ROM latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsel_q  <= '0;
            ok_q    <= 1'b0;
            col_q   <= '0;
            blank_q <= 1'b0;
        end else begin
            bsel_q  <= char_code[CODE_W-1 -: 2];
            ok_q    <= (int'(char_code) < CODE_LIM);
            col_q   <= cell_col;
            blank_q <= blank_in;
        end
    end

    pixel_select #(.NUM_BANKS(NUM_BANKS)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_bytes (bank_bytes),
        .bank_sel   (bsel_q),
        .code_ok    (ok_q),
        .col        (col_q),
        .blank      (blank_q),
        .fg_color   (fg_q),
        .bg_color   (bg_q),
        .pix        (pix_color)
    );

    // R8: a blanked pixel comes out black two edges later.
    a_r8_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        blank_in |-> ##2 (pix_color == '0));

    // R7: codes past the last bank show only the background colour.
    a_r7_high_code_bg: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_in && int'(char_code) >= CODE_LIM)
        |-> ##2 (pix_color == palette_entry($past(bg_idx, 2))));

    // R6: equal indices give that entry whatever the glyph bit is.
    a_r6_same_index: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_in && fg_idx == bg_idx)
        |-> ##2 (pix_color == palette_entry($past(fg_idx, 2))));

    // R5: index 0 on both palettes is black.
    a_r5_entry0_black: assert property (@(posedge clk) disable iff (!rst_n)
        (fg_idx == '0 && bg_idx == '0) |-> ##2 (pix_color == 6'h00));

    // R10: reset clears the output at the next edge.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pix_color == '0));

endmodule

// File: tb/glyph_pixel_render_bench.sv
// Bench: streams pixels every clock and checks each output two edges later
// against an arithmetic model built from the requirements.
module glyph_pixel_render_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] char_code = '0;
    logic [3:0] fg_idx = '0, bg_idx = '0;
    logic [2:0] cell_row = '0, cell_col = '0;
    logic       blank_in = 1'b0;
    logic [5:0] pix_color;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Expected-value pipeline, two deep.
    logic [5:0] exp1, exp2;
    bit         v1 = 0, v2 = 0;
    string      tag1, tag2;

    always #2 clk = ~clk;

    glyph_pixel_render u_glyph_pixel_render (
        .clk(clk), .rst_n(rst_n), .char_code(char_code),
        .fg_idx(fg_idx), .bg_idx(bg_idx), .cell_row(cell_row),
        .cell_col(cell_col), .blank_in(blank_in), .pix_color(pix_color)
    );

    function automatic logic [5:0] pal(input int i);
        logic [5:0] t [16] = '{6'h00, 6'h3F, 6'h03, 6'h0C, 6'h30, 6'h0F, 6'h33, 6'h3C,
                               6'h15, 6'h2A, 6'h01, 6'h04, 6'h10, 6'h05, 6'h14, 6'h11};
        return t[i];
    endfunction

    function automatic bit glyph_bit(input int c, input int r, input int k);
        int rb;
        if (c >= 192) return 1'b0;
        rb = c ^ (r * 32 + (r % 4) * 8 + r);
        return ((rb >> (7 - k)) & 1) != 0;
    endfunction

    function automatic logic [5:0] model(input int c, input int r, input int k,
                                         input int f, input int b, input bit bl);
        if (bl) return 6'h00;
        return glyph_bit(c, r, k) ? pal(f) : pal(b);
    endfunction

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // One pixel per clock: check the pixel from two clocks ago, then drive.
    task automatic step(input int c, input int r, input int k, input int f,
                        input int b, input bit bl, input bit vld, input string tag);
        @(negedge clk);
        if (v2) check(pix_color, exp2, tag2);
        v2 = v1; exp2 = exp1; tag2 = tag1;
        v1 = vld; exp1 = model(c, r, k, f, b, bl); tag1 = tag;
        char_code = 8'(c); cell_row = 3'(r); cell_col = 3'(k);
        fg_idx = 4'(f); bg_idx = 4'(b); blank_in = bl;
    endtask

    task automatic flush();
        step(0, 0, 0, 0, 0, 1'b1, 1'b0, "");
        step(0, 0, 0, 0, 0, 1'b1, 1'b0, "");
    endtask

    initial begin
        // R10: output held at zero under reset with busy inputs.
        char_code = 8'h80; fg_idx = 4'd1; bg_idx = 4'd2;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(pix_color, 6'h00, "R10 reset");
        end
        rst_n = 1'b1;

        // R3: column order on code 0x41 row 0 (byte 0x41: cols 1 and 7 set).
        for (int k = 0; k < 8; k++)
            step(8'h41, 0, k, 1, 0, 1'b0, 1'b1, "R3 column order");
        flush();
        n_tests++;
        if (!(glyph_bit(8'h41, 0, 1) && glyph_bit(8'h41, 0, 7) && !glyph_bit(8'h41, 0, 0))) begin
            n_fail++;
            $display("FAIL R3: model column bits wrong, got 0 expected 1");
        end

        // R1: same row and column across the three banks.
        for (int bk = 0; bk < 3; bk++)
            for (int r = 0; r < 8; r++)
                for (int k = 0; k < 8; k++)
                    step(bk * 64 + 1, r, k, 3, 4, 1'b0, 1'b1, "R1 bank addressing");
        flush();

        // R5: background palette sweep through an out-of-range code.
        for (int i = 0; i < 16; i++)
            step(200, 0, 0, 5, i, 1'b0, 1'b1, "R5 palette content");
        // R6: foreground sweep on a set bit with background held elsewhere.
        for (int i = 0; i < 16; i++)
            step(8'h80, 0, 0, i, 9, 1'b0, 1'b1, "R6 independent fg");
        for (int i = 0; i < 16; i++)
            step(8'h00, 0, 0, 7, i, 1'b0, 1'b1, "R6 independent bg");
        flush();

        // R9: alternating fg/bg pixels with single-cycle blank pulses.
        for (int i = 0; i < 24; i++)
            step(8'h80, 0, (i % 2) ? 1 : 0, 1, 2, (i % 7) == 3, 1'b1, "R9 back-to-back");
        flush();

        // Full sweep: every code, row and column, with sparse blanking.
        for (int c = 0; c < 256; c++)
            for (int r = 0; r < 8; r++)
                for (int k = 0; k < 8; k++) begin
                    int  f   = (c + r) % 16;
                    int  b   = (c * 3 + k + 1) % 16;
                    bit  bl  = ((c * 64 + r * 8 + k) % 37) == 5;
                    string t;
                    if (bl)                      t = "R8 blank";
                    else if (c >= 192)           t = "R7 high code";
                    else if (glyph_bit(c, r, k)) t = "R4 fg select";
                    else                         t = "R2 glyph content";
                    step(c, r, k, f, b, bl, 1'b1, t);
                end
        flush();

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule